// File: doc/BRIEF.md
# Parallel Video Pixel Output Formatter

This block sits at the end of a video decode pipeline and drives one sample per clock onto a 16-bit parallel pixel port. Each cycle it receives luma and chroma, red/green/blue components, and the timing flags of the current sample. It packs the components into one of three bus layouts: 4:2:2 luma/chroma on two byte lanes, 5-6-5 RGB, or 5-5-5 RGB. During blanking it forces the bus to a fixed black code unless the sample carries vertical-interval data. All outputs leave through one register stage, so the bus and the timing flags stay aligned.

The data-valid strobe has two modes. In the plain mode it marks only active-video samples. In the padded mode it also marks blanking samples, so that every line carries a programmed number of valid samples. Padding starts after the line's active region ends. On a line flagged as having no active video, padding starts at the line's first sample. The format, the strobe mode, the line total and the no-active-line flag are captured on the first sample of each line and held until the next line starts.

Top module: `vfmt_out`

## Requirements
- R1: In luma/chroma format (`cfg_fmt_i` = 0, or the reserved code 3), `pix_o[15:8]` carries Y and `pix_o[7:0]` carries chroma. The chroma lane alternates between Cb and Cr.
- R2: The chroma phase restarts at Cb on the first sample of each line (the sample with `line_start_i` high). It advances by one only on samples with `active_i` high, so the first active sample of every line carries Cb.
- R3: In 5-6-5 RGB format (`cfg_fmt_i` = 1), bits 15:11 carry R[7:3], bits 10:5 carry G[7:2] and bits 4:0 carry B[7:3].
- R4: In 5-5-5 RGB format (`cfg_fmt_i` = 2), bits 14:10 carry R[7:3], bits 9:5 carry G[7:3] and bits 4:0 carry B[7:3]. Bit 15 is 0.
- R5: When `blank_i` is high and `vbi_valid_i` is low, the bus is 16'h1080 (Y=16, chroma=128) in luma/chroma format and 16'h0000 in both RGB formats. When `vbi_valid_i` is high, the packed data passes through even during blanking.
- R6: Unless both strobe-mode bits were set at line start, `dvalid_o` equals `active_i` of the same sample.
- R7: When both strobe-mode bits were set at line start, every active sample is valid, and every sample counts toward the line total when it is valid. Once the line's active region has ended, each blanking sample is marked valid while the count is below the captured line total. No further sample is marked after the count reaches the total.
- R8: In padded mode, on a line whose `vbl_line_i` was high at line start, padding applies to blanking samples from the first sample of the line.
- R9: Format, strobe mode, line total and the no-active-line flag take effect only on a sample with `line_start_i` high. Changes in the middle of a line have no effect until the next line.
- R10: Every output appears one clock after its input sample. `blank_o`, `hsync_o`, `vsync_o`, `field_o` and `vbi_valid_o` are copies of the matching inputs delayed by one clock.
- R11: While `rst_n` is low, all outputs are 0. After reset, the format is luma/chroma, padding is off, and the chroma phase is Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | First sample of a line |
| active_i | input | 1 | Sample is active video |
| blank_i | input | 1 | Sample lies in a blanking interval |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| field_i | input | 1 | Field identifier |
| vbi_valid_i | input | 1 | Sample carries vertical-interval data |
| vbl_line_i | input | 1 | Line has no active region (captured at line start) |
| cfg_fmt_i | input | 2 | Bus format: 0 luma/chroma, 1 RGB 5-6-5, 2 RGB 5-5-5, 3 luma/chroma |
| cfg_pad_en_i | input | 1 | Strobe-mode bit A |
| cfg_pad_arm_i | input | 1 | Strobe-mode bit B (padding needs A and B) |
| cfg_line_total_i | input | CNT_W | Valid samples per line in padded mode |
| y_i | input | 8 | Luma |
| cb_i | input | 8 | Blue-difference chroma |
| cr_i | input | 8 | Red-difference chroma |
| r_i | input | 8 | Red |
| g_i | input | 8 | Green |
| b_i | input | 8 | Blue |
| pix_o | output | 16 | Pixel bus |
| dvalid_o | output | 1 | Data-valid strobe |
| blank_o | output | 1 | Registered blanking flag |
| hsync_o | output | 1 | Registered horizontal sync |
| vsync_o | output | 1 | Registered vertical sync |
| vbi_valid_o | output | 1 | Registered vertical-interval data flag |
| field_o | output | 1 | Registered field flag |

## Verification
Two pairs of events can fall on the same sample. A line start can coincide with the first active sample, so the configuration capture and the chroma-phase restart act on the same pixel. A line start can also arrive while padding is still below its total, so the counter restart and the strobe decision meet in one cycle. The stimulus provokes both: some lines have no blanking before active video, and some lines are too short to reach their total. Other lines change the configuration mid-line. A per-sample reference model in the bench predicts the bus and the strobe from the requirements, and each sample is compared one clock later.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  typedef enum logic [1:0] {
    FMT_YCC16 = 2'd0,
    FMT_RGB16 = 2'd1,
    FMT_RGB15 = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  localparam int COMP_W = 8;
  localparam int PIX_W  = 16;
  localparam logic [COMP_W-1:0] BLK_LUMA   = 8'd16;
  localparam logic [COMP_W-1:0] BLK_CHROMA = 8'd128;
endpackage

// File: rtl/vfmt_line_ctl.sv
module vfmt_line_ctl
  import vfmt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start_i,
  input  logic             active_i,
  input  logic [1:0]       cfg_fmt_i,
  input  logic             cfg_pad_en_i,
  input  logic             cfg_pad_arm_i,
  input  logic [CNT_W-1:0] cfg_total_i,
  input  logic             vbl_line_i,
  output fmt_e             fmt_o,
  output logic             pad_mode_o,
  output logic [CNT_W-1:0] total_o,
  output logic             vbl_o,
  output logic             cr_sel_o,
  output logic             seen_act_o
);
  fmt_e             fmt_q, fmt_d;
  logic             pad_q, pad_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic             vbl_q, vbl_d;
  logic             phase_q, phase_d;
  logic             seen_q, seen_d;
  logic             phase_cur, seen_cur;

  // Current-sample view: a line start overrides held state on that sample.
  always_comb begin
    if (line_start_i) begin
      fmt_o      = fmt_e'(cfg_fmt_i);
      pad_mode_o = cfg_pad_en_i & cfg_pad_arm_i;
      total_o    = cfg_total_i;
      vbl_o      = vbl_line_i;
      phase_cur  = 1'b0;
      seen_cur   = 1'b0;
    end else begin
      fmt_o      = fmt_q;
      pad_mode_o = pad_q;
      total_o    = total_q;
      vbl_o      = vbl_q;
      phase_cur  = phase_q;
      seen_cur   = seen_q;
    end
    cr_sel_o   = phase_cur;
    seen_act_o = seen_cur;
  end

  always_comb begin
    fmt_d   = fmt_o;
    pad_d   = pad_mode_o;
    total_d = total_o;
    vbl_d   = vbl_o;
    phase_d = active_i ? ~phase_cur : phase_cur;
    seen_d  = seen_cur | active_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= FMT_YCC16;
      pad_q   <= 1'b0;
      total_q <= '0;
      vbl_q   <= 1'b0;
      phase_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      fmt_q   <= fmt_d;
      pad_q   <= pad_d;
      total_q <= total_d;
      vbl_q   <= vbl_d;
      phase_q <= phase_d;
      seen_q  <= seen_d;
    end
  end
endmodule

// File: rtl/vfmt_valid_gen.sv
module vfmt_valid_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start_i,
  input  logic             active_i,
  input  logic             pad_mode_i,
  input  logic             vbl_i,
  input  logic             seen_act_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             dv_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_cur;
  logic             pad;

  always_comb begin
    cnt_cur = line_start_i ? '0 : cnt_q;
    pad     = pad_mode_i & ~active_i & (seen_act_i | vbl_i) & (cnt_cur < total_i);
    dv_o    = active_i | pad;
    cnt_d   = cnt_cur;
    if (dv_o && (cnt_cur != CNT_MAX)) cnt_d = cnt_cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vfmt_pack.sv
module vfmt_pack
  import vfmt_pkg::*;
(
  input  fmt_e              fmt_i,
  input  logic              cr_sel_i,
  input  logic              force_blk_i,
  input  logic [COMP_W-1:0] y_i,
  input  logic [COMP_W-1:0] cb_i,
  input  logic [COMP_W-1:0] cr_i,
  input  logic [COMP_W-1:0] r_i,
  input  logic [COMP_W-1:0] g_i,
  input  logic [COMP_W-1:0] b_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [PIX_W-1:0] ycc, rgb16, rgb15;
  logic             unused_lsb;

  assign unused_lsb = ^{r_i[2:0], g_i[1:0], b_i[2:0]};

  always_comb begin
    ycc   = {y_i, (cr_sel_i ? cr_i : cb_i)};
    rgb16 = {r_i[7:3], g_i[7:2], b_i[7:3]};
    rgb15 = {1'b0, r_i[7:3], g_i[7:3], b_i[7:3]};
    unique case (fmt_i)
      FMT_RGB16: pix_o = force_blk_i ? '0 : rgb16;
      FMT_RGB15: pix_o = force_blk_i ? '0 : rgb15;
      default:   pix_o = force_blk_i ? {BLK_LUMA, BLK_CHROMA} : ycc;
    endcase
  end
endmodule

// File: rtl/vfmt_out.sv
module vfmt_out
  import vfmt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start_i,
  input  logic             active_i,
  input  logic             blank_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             field_i,
  input  logic             vbi_valid_i,
  input  logic             vbl_line_i,
  input  logic [1:0]       cfg_fmt_i,
  input  logic             cfg_pad_en_i,
  input  logic             cfg_pad_arm_i,
  input  logic [CNT_W-1:0] cfg_line_total_i,
  input  logic [7:0]       y_i,
  input  logic [7:0]       cb_i,
  input  logic [7:0]       cr_i,
  input  logic [7:0]       r_i,
  input  logic [7:0]       g_i,
  input  logic [7:0]       b_i,
  output logic [15:0]      pix_o,
  output logic             dvalid_o,
  output logic             blank_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             vbi_valid_o,
  output logic             field_o
);
  fmt_e             fmt_cur;
  logic             pad_mode, vbl_cur, cr_sel, seen_act, dv;
  logic [CNT_W-1:0] total_cur;
  logic [PIX_W-1:0] pix_d;
  logic             force_blk;

  vfmt_line_ctl #(.CNT_W(CNT_W)) u_line_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start_i),
    .active_i     (active_i),
    .cfg_fmt_i    (cfg_fmt_i),
    .cfg_pad_en_i (cfg_pad_en_i),
    .cfg_pad_arm_i(cfg_pad_arm_i),
    .cfg_total_i  (cfg_line_total_i),
    .vbl_line_i   (vbl_line_i),
    .fmt_o        (fmt_cur),
    .pad_mode_o   (pad_mode),
    .total_o      (total_cur),
    .vbl_o        (vbl_cur),
    .cr_sel_o     (cr_sel),
    .seen_act_o   (seen_act)
  );

  vfmt_valid_gen #(.CNT_W(CNT_W)) u_valid_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start_i(line_start_i),
    .active_i    (active_i),
    .pad_mode_i  (pad_mode),
    .vbl_i       (vbl_cur),
    .seen_act_i  (seen_act),
    .total_i     (total_cur),
    .dv_o        (dv)
  );

  assign force_blk = blank_i & ~vbi_valid_i;

  vfmt_pack u_pack (
    .fmt_i      (fmt_cur),
    .cr_sel_i   (cr_sel),
    .force_blk_i(force_blk),
    .y_i        (y_i),
    .cb_i       (cb_i),
    .cr_i       (cr_i),
    .r_i        (r_i),
    .g_i        (g_i),
    .b_i        (b_i),
    .pix_o      (pix_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_o       <= '0;
      dvalid_o    <= 1'b0;
      blank_o     <= 1'b0;
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      vbi_valid_o <= 1'b0;
      field_o     <= 1'b0;
    end else begin
      pix_o       <= pix_d;
      dvalid_o    <= dv;
      blank_o     <= blank_i;
      hsync_o     <= hsync_i;
      vsync_o     <= vsync_i;
      vbi_valid_o <= vbi_valid_i;
      field_o     <= field_i;
    end
  end

  AST_ACTIVE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> dvalid_o); // R7
  AST_PLAIN_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_mode && !active_i) |=> !dvalid_o); // R6
  AST_BLANK_YCC: assert property (@(posedge clk) disable iff (!rst_n)
    (force_blk && (fmt_cur == FMT_YCC16)) |=> (pix_o == 16'h1080)); // R5
  AST_BLANK_RGB: assert property (@(posedge clk) disable iff (!rst_n)
    (force_blk && ((fmt_cur == FMT_RGB16) || (fmt_cur == FMT_RGB15))) |=> (pix_o == 16'h0000)); // R5
  AST_RGB15_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_cur == FMT_RGB15) |=> !pix_o[15]); // R4
  AST_FIRST_CB: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && active_i && !force_blk && (fmt_cur == FMT_YCC16)) |=> (pix_o[7:0] == $past(cb_i))); // R2
  AST_HSYNC_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i |=> hsync_o); // R10
  AST_BLANK_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_i |=> !blank_o); // R10
endmodule

// File: tb/vfmt_out_tb.sv
module vfmt_out_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic clk, rst_n;
  logic line_start, active, blank, hsync, vsync, field, vbi, vbl;
  logic [1:0] cfg_fmt;
  logic cfg_pa, cfg_pb;
  logic [CNT_W-1:0] cfg_total;
  logic [7:0] y, cb, cr, r, g, b;
  logic [15:0] pix;
  logic dvalid, blank_o, hsync_o, vsync_o, vbi_o, field_o;

  int n_checks = 0;
  int n_fail = 0;
  string note = "";

  // reference model state
  logic [1:0] m_fmt;
  logic m_pad, m_vbl, m_phase, m_seen;
  logic [CNT_W-1:0] m_total, m_cnt;

  vfmt_out #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .active_i(active),
    .blank_i(blank), .hsync_i(hsync), .vsync_i(vsync), .field_i(field),
    .vbi_valid_i(vbi), .vbl_line_i(vbl), .cfg_fmt_i(cfg_fmt),
    .cfg_pad_en_i(cfg_pa), .cfg_pad_arm_i(cfg_pb), .cfg_line_total_i(cfg_total),
    .y_i(y), .cb_i(cb), .cr_i(cr), .r_i(r), .g_i(g), .b_i(b),
    .pix_o(pix), .dvalid_o(dvalid), .blank_o(blank_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .vbi_valid_o(vbi_o), .field_o(field_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, note, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pix(logic [1:0] f, logic crs, logic frc);
    case (f)
      2'd1: return frc ? 16'h0000 : {r[7:3], g[7:2], b[7:3]};
      2'd2: return frc ? 16'h0000 : {1'b0, r[7:3], g[7:3], b[7:3]};
      default: return frc ? 16'h1080 : {y, crs ? cr : cb};
    endcase
  endfunction

  function automatic string fmt_tag(logic [1:0] f, logic frc);
    if (frc) return "R5";
    if (f == 2'd1) return "R3";
    if (f == 2'd2) return "R4";
    return "R1";
  endfunction

  // Inputs are already applied; predict, clock, compare one cycle later.
  task automatic tick();
    logic [15:0] ep;
    logic ed, pad, frc;
    logic [6:0] flags;
    string pt, dt;
    if (line_start) begin
      m_fmt = cfg_fmt; m_pad = cfg_pa & cfg_pb; m_total = cfg_total;
      m_vbl = vbl; m_phase = 1'b0; m_cnt = '0; m_seen = 1'b0;
    end
    frc = blank & ~vbi;
    ep  = exp_pix(m_fmt, m_phase, frc);
    pt  = fmt_tag(m_fmt, frc);
    pad = m_pad & ~active & (m_seen | m_vbl) & (m_cnt < m_total);
    ed  = active | pad;
    dt  = m_pad ? (m_vbl ? "R8" : "R7") : "R6";
    flags = {blank, hsync, vsync, vbi, field, 2'b00};
    if (active) m_phase = ~m_phase;
    if (ed && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
    m_seen = m_seen | active;
    @(posedge clk); #1;
    chk(pt, pix, ep);
    chk(dt, {15'd0, dvalid}, {15'd0, ed});
    chk("R10", {9'd0, blank_o, hsync_o, vsync_o, vbi_o, field_o, 2'b00}, {9'd0, flags});
    @(negedge clk);
  endtask

  task automatic rand_data();
    {y, cb, cr} = {$urandom, $urandom};
    {r, g, b}   = {$urandom, $urandom};
  endtask

  // One line: pre-blank, active, post-blank samples. mid_cfg scrambles config after first sample (R9).
  task automatic run_line(int pre, int act, int post, logic vbl_l, logic rnd_blank, logic mid_cfg);
    int len = pre + act + post;
    for (int i = 0; i < len; i++) begin
      line_start = (i == 0);
      active = (i >= pre) && (i < pre + act);
      blank  = rnd_blank ? 1'($urandom) : ~active;
      vbi    = rnd_blank ? 1'($urandom) : 1'b0;
      hsync  = (i < 2);
      vbl    = (i == 0) ? vbl_l : 1'($urandom);
      if (mid_cfg && i > 0) begin
        cfg_fmt = 2'($urandom); cfg_pa = 1'($urandom); cfg_pb = 1'($urandom);
        cfg_total = CNT_W'($urandom % 64);
      end
      rand_data();
      tick();
    end
  endtask

  task automatic set_cfg(logic [1:0] f, logic pa, logic pb, int tot);
    cfg_fmt = f; cfg_pa = pa; cfg_pb = pb; cfg_total = CNT_W'(tot);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    {line_start, active, blank, hsync, vsync, field, vbi, vbl} = '0;
    set_cfg(2'd1, 1'b1, 1'b1, 9);
    rand_data();
    m_fmt = 2'd0; m_pad = 1'b0; m_vbl = 1'b0; m_phase = 1'b0; m_seen = 1'b0;
    m_total = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    note = "reset";
    chk("R11", pix, 16'h0000);
    chk("R11", {9'd0, dvalid, blank_o, hsync_o, vsync_o, vbi_o, field_o}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // no line start yet: reset state must apply (luma/chroma, no padding)
    note = "R11 post-reset defaults";
    active = 1'b1; blank = 1'b0; tick(); tick();
    active = 1'b0; blank = 1'b1; tick();

    note = "R2 luma/chroma line, Cb first";
    set_cfg(2'd0, 1'b0, 1'b0, 0);
    run_line(3, 8, 4, 1'b0, 1'b0, 1'b0);
    note = "R2 reserved code as luma/chroma, active from first sample";
    set_cfg(2'd3, 1'b0, 1'b0, 0);
    run_line(0, 7, 3, 1'b0, 1'b0, 1'b0);
    note = "R3 rgb 5-6-5";
    set_cfg(2'd1, 1'b0, 1'b1, 40);
    run_line(2, 6, 5, 1'b0, 1'b0, 1'b0);
    note = "R4 rgb 5-5-5";
    set_cfg(2'd2, 1'b1, 1'b0, 40);
    run_line(2, 6, 5, 1'b0, 1'b0, 1'b0);
    note = "R7 padding reaches total then stops";
    set_cfg(2'd0, 1'b1, 1'b1, 20);
    run_line(2, 8, 16, 1'b0, 1'b0, 1'b0);
    note = "R7 total below active count, no padding";
    set_cfg(2'd0, 1'b1, 1'b1, 5);
    run_line(2, 8, 6, 1'b0, 1'b0, 1'b0);
    note = "R7 line ends before total, restart at line start";
    set_cfg(2'd1, 1'b1, 1'b1, 30);
    run_line(1, 4, 3, 1'b0, 1'b0, 1'b0);
    run_line(0, 4, 30, 1'b0, 1'b0, 1'b0);
    note = "R8 no-active line padded from start";
    set_cfg(2'd0, 1'b1, 1'b1, 6);
    run_line(10, 0, 0, 1'b1, 1'b0, 1'b0);
    note = "R5 vertical-interval data passes through blanking";
    set_cfg(2'd2, 1'b0, 1'b0, 0);
    run_line(2, 3, 8, 1'b0, 1'b1, 1'b0);
    set_cfg(2'd0, 1'b0, 1'b0, 0);
    run_line(2, 3, 8, 1'b0, 1'b1, 1'b0);
    note = "R9 mid-line config change ignored";
    set_cfg(2'd0, 1'b1, 1'b1, 12);
    run_line(1, 6, 10, 1'b0, 1'b0, 1'b1);
    set_cfg(2'd2, 1'b0, 1'b0, 0);
    run_line(2, 6, 4, 1'b0, 1'b0, 1'b1);

    note = "random lines";
    for (int ln = 0; ln < 400; ln++) begin
      int pre = $urandom % 5;
      int act = $urandom % 12;
      int post = $urandom % 14;
      set_cfg(2'($urandom), 1'($urandom), 1'($urandom), $urandom % 24);
      vsync = 1'($urandom % 8 == 0);
      field = 1'($urandom);
      run_line(pre, act, post, 1'($urandom % 4 == 0), 1'($urandom % 5 == 0), 1'($urandom % 3 == 0));
    end
    summary();
  end
endmodule